// File: doc/BRIEF.md
# Performance Counter Bank with Overflow

This block holds a bank of event counters for processor performance monitoring. There are two groups. The first is a parameterized set of general-purpose counters, and each of these has its own event-select register. The second is a set of fixed-function counters, all controlled by 4-bit fields packed into one shared control register. Every cycle, each counter receives a small increment value from event logic outside the block. A counter adds that value only when three conditions hold together:

- its local enable is set,
- its bit in the global enable register is set,
- the current privilege mode is one the counter is qualified for.

A counter overflows when it wraps past all-ones. The overflow sets a sticky bit in a global status register. Software clears those bits by writing a mask to a separate clear register. A level interrupt request is raised while any set status bit belongs to a counter that asked for an interrupt.

Software uses a simple register port. A write takes effect at the clock edge. A read is combinational from the address. To generate an interrupt after N events, software presets a counter to the two's-complement value (1 − N). It can rewrite a counter at any time, including while the counter is running.

Top module: `perf_counter_bank`

## Requirements
- R1: A general-purpose counter adds its per-cycle increment when its enable bit (select bit 19), its global enable bit and its mode qualifier are all set. Otherwise the counter holds its value.
- R2: While `mode_user` is 0, select bit 16 qualifies counting. While `mode_user` is 1, select bit 17 qualifies counting instead.
- R3: Global enable bit i gates general-purpose counter i. Bit 32+j gates fixed counter j. A counter whose global bit is clear does not change.
- R4: A counter that wraps from all-ones to zero sets its status bit. A counter preset to (1 − N) holds exactly 1 after N single events.
- R5: A status bit stays set until software clears it.
- R6: Writing a mask to the clear register (address 0x33) clears exactly the masked status bits. An overflow in the same cycle as the clear keeps its bit set.
- R7: A write to a counter replaces its value in the same cycle, and the write takes priority over any increment. A running counter written to all-ones overflows on its next event.
- R8: `irq` is high while any set status bit belongs to a counter with its interrupt bit set. For a general-purpose counter that is select bit 18; for a fixed counter it is field bit 3. An overflow on a counter without this bit raises no interrupt.
- R9: A nonzero threshold in select bits [27:20] changes how the counter counts. It adds 1 in each qualified cycle whose increment is at least the threshold, and adds 0 in all other cycles.
- R10: Fixed counter j uses control bits [4j+3:4j]. Bit 0 is kernel enable, bit 1 is user enable and bit 3 is interrupt enable.
- R11: After reset, every counter, select, control, enable and status register reads 0, and `irq` is 0.
- R12: An event-select register reads back as written in bits [27:0]. Bits [15:0] hold the event selector, which is stored but has no effect on counting.

Register map (write and read unless noted):

| Address | Register |
|---|---|
| 0x00+i | general-purpose counter i |
| 0x10+i | event-select register i |
| 0x20+j | fixed counter j |
| 0x30 | fixed control |
| 0x31 | global enable |
| 0x32 | status (read only) |
| 0x33 | status clear (write only) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_user | input | 1 | Current privilege mode: 1 is user, 0 is kernel |
| gp_evt | input | NGP*INCW | Per-cycle increment for each general-purpose counter |
| fx_evt | input | NFIX*INCW | Per-cycle increment for each fixed counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach from the ports are the ones that meet at the wrap point. These are a write and an event landing on the same edge, an overflow landing together with a status clear, and a threshold gate that has to drop some cycles. To get there, the stimulus presets counters to a few counts below all-ones through the register port and then releases single events one cycle at a time. It also drives events continuously while a counter is being rewritten, so that the write and the increment meet on one edge. Per-cycle increment patterns of 1, 2, 3 and 1 show the threshold count against the plain count.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NGP      = 4,
  parameter int NFIX     = 3,
  parameter int GPW      = 48,
  parameter int FXW      = 48,
  parameter int INCW     = 2,
  parameter int FIX_BASE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_user,
  input  logic [NGP*INCW-1:0]  gp_evt,
  input  logic [NFIX*INCW-1:0] fx_evt,
  input  logic                 wr_en,
  input  logic [5:0]           addr,
  input  logic [63:0]          wdata,
  output logic [63:0]          rdata,
  output logic                 irq
);
  localparam int SELW = 28;
  localparam int THRW = 8;
  localparam logic [5:0] A_GPCNT = 6'h00, A_SEL = 6'h10, A_FXCNT = 6'h20;
  localparam logic [5:0] A_FXCTL = 6'h30, A_GEN = 6'h31, A_STAT = 6'h32, A_CLR = 6'h33;

  logic [NGP-1:0][GPW-1:0]  gp_cnt, gp_nxt;
  logic [NGP-1:0][SELW-1:0] gp_sel;
  logic [NFIX-1:0][FXW-1:0] fx_cnt, fx_nxt;
  logic [4*NFIX-1:0]        fx_ctl;
  logic [NGP-1:0]           gp_ovf, gp_wr;
  logic [NFIX-1:0]          fx_ovf, fx_wr;
  logic [63:0]              gen_q, status_q, ovf, int_mask, gvalid;

  for (genvar g = 0; g < NGP; g++) begin : g_gp
    wire [INCW-1:0] ev   = gp_evt[g*INCW +: INCW];
    wire [THRW-1:0] thr  = gp_sel[g][27:20];
    wire            qual = gp_sel[g][19] & gen_q[g] &
                           (mode_user ? gp_sel[g][17] : gp_sel[g][16]);
    wire [INCW-1:0] inc  = (thr == '0) ? ev :
                           ((THRW'(ev) >= thr) ? INCW'(1) : '0);
    wire [GPW:0]    sum  = {1'b0, gp_cnt[g]} + (GPW+1)'(qual ? inc : '0);
    assign gp_wr[g]  = wr_en && (addr == 6'(A_GPCNT + g));
    assign gp_nxt[g] = sum[GPW-1:0];
    assign gp_ovf[g] = sum[GPW] & ~gp_wr[g];
  end

  for (genvar j = 0; j < NFIX; j++) begin : g_fx
    wire [3:0]      f    = fx_ctl[4*j +: 4];
    wire            qual = gen_q[FIX_BASE+j] & (mode_user ? f[1] : f[0]);
    wire [FXW:0]    sum  = {1'b0, fx_cnt[j]} + (FXW+1)'(qual ? fx_evt[j*INCW +: INCW] : '0);
    assign fx_wr[j]  = wr_en && (addr == 6'(A_FXCNT + j));
    assign fx_nxt[j] = sum[FXW-1:0];
    assign fx_ovf[j] = sum[FXW] & ~fx_wr[j];
  end

  always_comb begin
    ovf = '0; int_mask = '0; gvalid = '0;
    ovf[NGP-1:0]            = gp_ovf;
    ovf[FIX_BASE +: NFIX]   = fx_ovf;
    gvalid[NGP-1:0]          = '1;
    gvalid[FIX_BASE +: NFIX] = '1;
    for (int g = 0; g < NGP; g++)  int_mask[g]          = gp_sel[g][18];
    for (int j = 0; j < NFIX; j++) int_mask[FIX_BASE+j] = fx_ctl[4*j+3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp_cnt <= '0; gp_sel <= '0; fx_cnt <= '0; fx_ctl <= '0;
      gen_q <= '0; status_q <= '0;
    end else begin
      for (int g = 0; g < NGP; g++) begin
        gp_cnt[g] <= gp_wr[g] ? wdata[GPW-1:0] : gp_nxt[g];
        if (wr_en && addr == 6'(A_SEL + g)) gp_sel[g] <= wdata[SELW-1:0];
      end
      for (int j = 0; j < NFIX; j++)
        fx_cnt[j] <= fx_wr[j] ? wdata[FXW-1:0] : fx_nxt[j];
      if (wr_en && addr == A_FXCTL) fx_ctl <= wdata[4*NFIX-1:0];
      if (wr_en && addr == A_GEN)   gen_q  <= wdata & gvalid;
      status_q <= (status_q & ~((wr_en && addr == A_CLR) ? wdata : 64'h0)) | ovf;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_FXCTL)     rdata = 64'(fx_ctl);
    else if (addr == A_GEN)  rdata = gen_q;
    else if (addr == A_STAT) rdata = status_q;
    for (int g = 0; g < NGP; g++) begin
      if (addr == 6'(A_GPCNT + g)) rdata = 64'(gp_cnt[g]);
      if (addr == 6'(A_SEL + g))   rdata = 64'(gp_sel[g]);
    end
    for (int j = 0; j < NFIX; j++)
      if (addr == 6'(A_FXCNT + j)) rdata = 64'(fx_cnt[j]);
  end

  assign irq = |(status_q & int_mask);
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NGP = 4,
  parameter int GPW = 48
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [5:0]         addr,
  input logic [63:0]        wdata,
  input logic               irq,
  input logic [63:0]        status,
  input logic [63:0]        ovf,
  input logic [63:0]        gen,
  input logic [NGP*GPW-1:0] gp_flat
);
  wire clr_wr = wr_en && (addr == 6'h33);
  wire any_wr = wr_en;

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status) & ~($past(clr_wr) ? $past(wdata) : 64'h0)) == 64'h0));

  assert_clear_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_wr) |-> ((status & $past(wdata) & ~$past(ovf)) == 64'h0));

  assert_overflow_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != 64'h0) |=> ((status & $past(ovf)) == $past(ovf)));

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 64'h0));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen[NGP-1:0]) == '0 && !$past(any_wr)) |-> $stable(gp_flat));
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.NGP(NGP), .GPW(GPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .status(status_q), .ovf(ovf), .gen(gen_q), .gp_flat(gp_cnt)
);

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
  logic        clk = 0, rst_n = 0, mode_user = 0, wr_en = 0, irq;
  logic [7:0]  gp_evt = '0;
  logic [5:0]  fx_evt = '0;
  logic [5:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [63:0] ONES48 = 64'h0000_FFFF_FFFF_FFFF;

  perf_counter_bank u_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .gp_evt(gp_evt),
    .fx_evt(fx_evt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  // {kind, addr, data}: kind 0 write, 1 compare read, 2 run data cycles with unit events
  localparam int NV = 15;
  localparam logic [71:0] TBL [NV] = '{
    {2'd0, 6'h31, 64'h0000_0007_0000_000F},  // R3 enables
    {2'd0, 6'h10, 64'h0009_0000},            // en+kernel
    {2'd0, 6'h30, 64'h1},                    // R10 fixed0 kernel
    {2'd1, 6'h10, 64'h0009_0000},            // R12
    {2'd2, 6'h00, 64'd10},
    {2'd1, 6'h00, 64'd10},                   // R1
    {2'd1, 6'h20, 64'd10},                   // R10
    {2'd1, 6'h01, 64'd0},                    // R1 not enabled
    {2'd0, 6'h31, 64'h1},
    {2'd2, 6'h00, 64'd5},
    {2'd1, 6'h00, 64'd15},                   // R3
    {2'd1, 6'h20, 64'd10},                   // R3 fixed gated
    {2'd0, 6'h10, 64'h000A_0000},            // en+user
    {2'd2, 6'h00, 64'd4},
    {2'd1, 6'h00, 64'd15}                    // R2 kernel mode, user-only
  };

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string tag, logic [5:0] a, logic [63:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic run(int n);
    gp_evt = {4{2'b01}}; fx_evt = {3{2'b01}};
    repeat (n) @(negedge clk);
    gp_evt = '0; fx_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd("R11 gp0", 6'h00, 0); rd("R11 sel0", 6'h10, 0); rd("R11 fxctl", 6'h30, 0);
    rd("R11 gen", 6'h31, 0); rd("R11 status", 6'h32, 0);
    chk("R11 irq", 64'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i][71:70])
        2'd0: wr(TBL[i][69:64], TBL[i][63:0]);
        2'd1: rd($sformatf("table[%0d]", i), TBL[i][69:64], TBL[i][63:0]);
        default: run(int'(TBL[i][63:0]));
      endcase
    end

    // R2 user mode now qualifies
    mode_user = 1; run(3); mode_user = 0;
    rd("R2 user count", 6'h00, 18);

    // R4 preset 1-N, N=4, with interrupt
    wr(6'h10, 64'h000D_0000);
    wr(6'h00, 64'h0000_FFFF_FFFF_FFFD);
    run(4);
    rd("R4 ends at 1", 6'h00, 1);
    rd("R4 status", 6'h32, 64'h1);
    chk("R8 irq raised", 64'(irq), 1);
    wr(6'h33, 64'h1);
    rd("R6 cleared", 6'h32, 0);
    chk("R8 irq drops", 64'(irq), 0);

    // R8 overflow without interrupt bit
    wr(6'h11, 64'h0009_0000);
    wr(6'h31, 64'hF);
    wr(6'h01, ONES48);
    run(1);
    rd("R8 status no-int", 6'h32, 64'h2);
    chk("R8 no irq", 64'(irq), 0);
    wr(6'h00, ONES48);
    run(1);
    rd("R4 both set", 6'h32, 64'h3);
    chk("R8 irq with int", 64'(irq), 1);
    wr(6'h33, 64'h1);
    rd("R6 exact clear", 6'h32, 64'h2);
    chk("R8 irq after partial clear", 64'(irq), 0);
    run(5);
    rd("R5 sticky", 6'h32, 64'h2);
    wr(6'h33, 64'h2);
    rd("R6 clear rest", 6'h32, 0);

    // R10 fixed1 field at bits [7:4]: kernel + interrupt
    wr(6'h30, 64'h90);
    wr(6'h31, 64'h0000_0002_0000_0000);
    wr(6'h21, ONES48);
    run(1);
    rd("R10 fixed wrap", 6'h21, 0);
    rd("R10 fixed status bit33", 6'h32, 64'h0000_0002_0000_0000);
    chk("R8 fixed irq", 64'(irq), 1);
    wr(6'h33, 64'h0000_0002_0000_0000);

    // R9 threshold 2 against increments 1,2,3,1
    wr(6'h31, 64'h4);
    wr(6'h12, 64'h0029_0000);
    gp_evt = 8'h10; @(negedge clk);
    gp_evt = 8'h20; @(negedge clk);
    gp_evt = 8'h30; @(negedge clk);
    gp_evt = 8'h10; @(negedge clk);
    gp_evt = 0;
    rd("R9 thresholded", 6'h02, 2);
    wr(6'h12, 64'h0009_0000);
    gp_evt = 8'h10; @(negedge clk);
    gp_evt = 8'h20; @(negedge clk);
    gp_evt = 8'h30; @(negedge clk);
    gp_evt = 8'h10; @(negedge clk);
    gp_evt = 0;
    rd("R9 plain count", 6'h02, 9);

    // R7 write while running
    gp_evt = 8'h10;
    wr(6'h02, 64'd100);
    rd("R7 write wins", 6'h02, 100);
    @(negedge clk);
    rd("R7 counts on", 6'h02, 101);
    wr(6'h02, ONES48);
    rd("R7 all ones held", 6'h02, ONES48);
    rd("R7 no status yet", 6'h32, 0);
    @(negedge clk);
    gp_evt = 0;
    rd("R7 wrapped", 6'h02, 0);
    rd("R7 status bit2", 6'h32, 64'h4);

    finish_run();
  end
endmodule